// File: doc/BRIEF.md
# Multilevel Cell Program-and-Verify Write Sequencer

This block writes one 2-bit multilevel resistive cell to a requested symbol. A write request carries the target symbol. The block then drives abstract pulse commands and verify reads to a cell interface, and judges every sensed level that comes back. It finishes with a one-cycle done strobe, a fail flag, and the total number of pulses it issued.

The 2-bit symbols use this encoding: `00` is fully amorphous (highest resistance), `11` is fully crystalline (lowest resistance), and `01` and `10` are the two intermediate levels. The block never moves a cell straight to its target.
- Every write starts with a long, low SET pulse, which takes the cell to `11`.
- For `00`, a short, high RESET pulse follows.
- For an intermediate symbol, the cell is taken first to `00`. Short partial pulses then step it toward the target, with a verify read after each pulse. The partial pulses stop at the first match or when a budget runs out.

Pulse widths, the settle gap and the partial-pulse budget are parameters counted in clock cycles.

Top module: `mlc_pv_writer`

## Requirements
- R1: After reset, and while `rst_ni` is low, the outputs are as follows: `ready_o` is high; the command outputs `pulse_set_o`, `pulse_reset_o`, `pulse_part_o` and `verify_o` are low; `done_o` and `fail_o` are low; and `pulse_cnt_o` is 0.
- R2: `req_i` is accepted only when `ready_o` is high, and `target_i` is captured at that point. `ready_o` is low from the next cycle until the cycle in which `done_o` is high. A `req_i` that arrives while busy has no effect on the write in progress.
- R3: Target `11` issues one SET pulse and then one verify that expects `11`. On a match it ends with success and a pulse count of 1.
- R4: Target `00` issues SET, a verify that expects `11`, RESET, and a verify that expects `00`. On success the pulse count is 2.
- R5: Target `01` or `10` runs the SET and RESET steps of R4 and then issues partial pulses. Each partial pulse is followed by a verify, and pulsing stops at the first verify that returns the target. On success after k partial pulses the pulse count is 2+k.
- R6: SET, RESET and partial pulses hold their output high for exactly SET_CYC, RESET_CYC and PART_CYC cycles. At most one pulse output is high at any time.
- R7: After every pulse there are exactly SETTLE_CYC cycles with no command before `verify_o` rises. `verify_o` stays high until `sense_valid_i` and is never high together with a pulse.
- R8: If the verify after the MAX_PART-th partial pulse does not match, the block ends with `done_o` and `fail_o` and a pulse count of MAX_PART+2. If that verify matches, the write succeeds.
- R9: A verify mismatch after the SET or RESET step ends the write at once with `done_o` and `fail_o`.
- R10: `done_o` is high for exactly one cycle, and `ready_o` is already high in that cycle. `fail_o` is high only together with `done_o`. `pulse_cnt_o` holds its final value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request |
| target_i | input | 2 | Target symbol |
| ready_o | output | 1 | Idle, can accept a request |
| pulse_set_o | output | 1 | SET pulse active |
| pulse_reset_o | output | 1 | RESET pulse active |
| pulse_part_o | output | 1 | Partial pulse active |
| verify_o | output | 1 | Verify read requested |
| sense_valid_i | input | 1 | Sensed level valid |
| sense_lvl_i | input | 2 | Sensed cell level |
| done_o | output | 1 | Write finished (one cycle) |
| fail_o | output | 1 | Write failed, valid with done_o |
| pulse_cnt_o | output | CNT_W | Total pulses issued by the last write |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- **Partial-pulse budget.** One write matches exactly on the last allowed partial pulse and must pass. Another needs one pulse more and must fail. An off-by-one limit turns one of these into the wrong outcome or gives a pulse count of 9 or 11 instead of 10.
- **Stuck cell.** A stub cell that ignores SET or RESET must cause an immediate failure after the detour step. A design that skips those verifies would keep pulsing, or would report success.
- **Pulse widths and settle gap.** These are measured on every pulse. A counter loaded with the width instead of the width minus one shows up as an extra cycle.
- **Busy requests and mid-write reset.** A request issued while busy must leave the running write untouched. A reset in the middle of a write must return every command to low.

// File: rtl/mlc_pv_pkg.sv
package mlc_pv_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_SETTLE, S_VERIFY} seq_state_e;
  typedef enum logic [1:0] {STEP_SET, STEP_RESET, STEP_PART} step_e;
  localparam logic [1:0] LVL_AMORPH = 2'b00;
  localparam logic [1:0] LVL_CRYST  = 2'b11;
endpackage

// File: rtl/mlc_pv_timer.sv
module mlc_pv_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  // len_i >= 1; zero_o marks the last cycle of the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mlc_pv_seq.sv
module mlc_pv_seq
  import mlc_pv_pkg::*;
#(
  parameter int SET_CYC    = 16,
  parameter int RESET_CYC  = 4,
  parameter int PART_CYC   = 3,
  parameter int SETTLE_CYC = 2,
  parameter int MAX_PART   = 8,
  parameter int CNT_W      = 4,
  parameter int TW         = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       target_i,
  input  logic             sense_valid_i,
  input  logic [1:0]       sense_lvl_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [TW-1:0]    tmr_len_o,
  output logic             ready_o,
  output logic             pulse_set_o,
  output logic             pulse_reset_o,
  output logic             pulse_part_o,
  output logic             verify_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] pulse_cnt_o
);
  localparam int PW = $clog2(MAX_PART + 1);

  seq_state_e       state_q, state_d;
  step_e            step_q, step_d;
  logic [1:0]       tgt_q, tgt_d;
  logic [PW-1:0]    part_q, part_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d, fail_q, fail_d;
  logic [1:0]       exp_lvl;
  logic             match;

  always_comb begin
    unique case (step_q)
      STEP_SET:   exp_lvl = LVL_CRYST;
      STEP_RESET: exp_lvl = LVL_AMORPH;
      default:    exp_lvl = tgt_q;
    endcase
  end
  assign match = (sense_lvl_i == exp_lvl);

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    tgt_d      = tgt_q;
    part_d     = part_q;
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    fail_d     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_len_o  = TW'(SETTLE_CYC);
    unique case (state_q)
      S_IDLE: if (req_i) begin
        state_d    = S_PULSE;
        step_d     = STEP_SET;
        tgt_d      = target_i;
        part_d     = '0;
        cnt_d      = CNT_W'(1);
        tmr_load_o = 1'b1;
        tmr_len_o  = TW'(SET_CYC);
      end
      S_PULSE: if (tmr_zero_i) begin
        state_d    = S_SETTLE;
        tmr_load_o = 1'b1;
      end
      S_SETTLE: if (tmr_zero_i) state_d = S_VERIFY;
      default: if (sense_valid_i) begin
        if (!match && step_q != STEP_PART) begin
          state_d = S_IDLE; done_d = 1'b1; fail_d = 1'b1;
        end else if (match && (step_q == STEP_PART || tgt_q == exp_lvl)) begin
          state_d = S_IDLE; done_d = 1'b1;
        end else if (!match && part_q == PW'(MAX_PART)) begin
          state_d = S_IDLE; done_d = 1'b1; fail_d = 1'b1;
        end else begin
          // next detour step or another partial pulse
          state_d    = S_PULSE;
          cnt_d      = cnt_q + CNT_W'(1);
          tmr_load_o = 1'b1;
          if (step_q == STEP_SET) begin
            step_d    = STEP_RESET;
            tmr_len_o = TW'(RESET_CYC);
          end else begin
            step_d    = STEP_PART;
            part_d    = part_q + PW'(1);
            tmr_len_o = TW'(PART_CYC);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= STEP_SET;
      tgt_q   <= '0;
      part_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      tgt_q   <= tgt_d;
      part_q  <= part_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign ready_o       = (state_q == S_IDLE);
  assign pulse_set_o   = (state_q == S_PULSE) && (step_q == STEP_SET);
  assign pulse_reset_o = (state_q == S_PULSE) && (step_q == STEP_RESET);
  assign pulse_part_o  = (state_q == S_PULSE) && (step_q == STEP_PART);
  assign verify_o      = (state_q == S_VERIFY);
  assign done_o        = done_q;
  assign fail_o        = fail_q;
  assign pulse_cnt_o   = cnt_q;

  // R6
  pulse_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pulse_set_o, pulse_reset_o, pulse_part_o}));
  // R7
  verify_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verify_o |-> !(pulse_set_o || pulse_reset_o || pulse_part_o));
  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
  // R10
  fail_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (done_o && ready_o));
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pulse_cnt_o) <= MAX_PART + 2);
endmodule

// File: rtl/mlc_pv_writer.sv
module mlc_pv_writer #(
  parameter int SET_CYC    = 16,
  parameter int RESET_CYC  = 4,
  parameter int PART_CYC   = 3,
  parameter int SETTLE_CYC = 2,
  parameter int MAX_PART   = 8,
  localparam int CNT_W     = $clog2(MAX_PART + 3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       target_i,
  output logic             ready_o,
  output logic             pulse_set_o,
  output logic             pulse_reset_o,
  output logic             pulse_part_o,
  output logic             verify_o,
  input  logic             sense_valid_i,
  input  logic [1:0]       sense_lvl_i,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] pulse_cnt_o
);
  localparam int MAX_A = (SET_CYC > RESET_CYC) ? SET_CYC : RESET_CYC;
  localparam int MAX_B = (PART_CYC > SETTLE_CYC) ? PART_CYC : SETTLE_CYC;
  localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_W + 1);

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_len;

  mlc_pv_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .zero_o (tmr_zero)
  );

  mlc_pv_seq #(
    .SET_CYC(SET_CYC), .RESET_CYC(RESET_CYC), .PART_CYC(PART_CYC),
    .SETTLE_CYC(SETTLE_CYC), .MAX_PART(MAX_PART), .CNT_W(CNT_W), .TW(TW)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .target_i      (target_i),
    .sense_valid_i (sense_valid_i),
    .sense_lvl_i   (sense_lvl_i),
    .tmr_zero_i    (tmr_zero),
    .tmr_load_o    (tmr_load),
    .tmr_len_o     (tmr_len),
    .ready_o       (ready_o),
    .pulse_set_o   (pulse_set_o),
    .pulse_reset_o (pulse_reset_o),
    .pulse_part_o  (pulse_part_o),
    .verify_o      (verify_o),
    .done_o        (done_o),
    .fail_o        (fail_o),
    .pulse_cnt_o   (pulse_cnt_o)
  );
endmodule

// File: tb/tb_mlc_pv_writer.sv
module tb_mlc_pv_writer;
  localparam int SET_CYC = 6, RESET_CYC = 2, PART_CYC = 3, SETTLE_CYC = 2, MAX_PART = 8;
  localparam int CNT_W = $clog2(MAX_PART + 3);

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [1:0] target = '0;
  logic ready, p_set, p_reset, p_part, verify, sv, done, fail;
  logic [1:0] slvl;
  logic [CNT_W-1:0] pcnt;
  int checks = 0, errs = 0;

  always #2 clk = ~clk;

  mlc_pv_writer #(.SET_CYC(SET_CYC), .RESET_CYC(RESET_CYC), .PART_CYC(PART_CYC),
                  .SETTLE_CYC(SETTLE_CYC), .MAX_PART(MAX_PART)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .target_i(target), .ready_o(ready),
    .pulse_set_o(p_set), .pulse_reset_o(p_reset), .pulse_part_o(p_part),
    .verify_o(verify), .sense_valid_i(sv), .sense_lvl_i(slvl),
    .done_o(done), .fail_o(fail), .pulse_cnt_o(pcnt));

  // behavioural cell stub: partial pulses advance one level every stub_steps pulses
  logic       stub_load = 1'b0, stub_stuck = 1'b0;
  logic [1:0] stub_init = '0, lvl;
  int         stub_steps = 1, sub;
  logic       prev_set, prev_reset, prev_part;

  always_ff @(posedge clk) begin
    prev_set <= p_set; prev_reset <= p_reset; prev_part <= p_part;
    sv   <= verify && !sv;
    slvl <= lvl;
    if (stub_load) begin
      lvl <= stub_init; sub <= 0;
    end else begin
      if (prev_set && !p_set && !stub_stuck) lvl <= 2'b11;
      if (prev_reset && !p_reset && !stub_stuck) lvl <= 2'b00;
      if (prev_part && !p_part) begin
        if (sub + 1 >= stub_steps) begin
          sub <= 0;
          if (lvl != 2'b11) lvl <= lvl + 2'b01;
        end else sub <= sub + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // pulse width and settle gap monitor
  int set_run = 0, reset_run = 0, part_run = 0, gap = 0;
  bit armed = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_set) set_run++;
      else if (set_run != 0) begin check(set_run == SET_CYC, "R6 set width", set_run, SET_CYC); set_run = 0; end
      if (p_reset) reset_run++;
      else if (reset_run != 0) begin check(reset_run == RESET_CYC, "R6 reset width", reset_run, RESET_CYC); reset_run = 0; end
      if (p_part) part_run++;
      else if (part_run != 0) begin check(part_run == PART_CYC, "R6 part width", part_run, PART_CYC); part_run = 0; end
      if (p_set || p_reset || p_part) begin
        gap = 0; armed = 1;
        if (32'(p_set) + 32'(p_reset) + 32'(p_part) > 1) check(0, "R6 onehot", 2, 1);
      end else if (armed && verify) begin
        check(gap == SETTLE_CYC, "R7 settle gap", gap, SETTLE_CYC);
        armed = 0;
      end else if (armed) gap++;
    end else begin
      set_run = 0; reset_run = 0; part_run = 0; gap = 0; armed = 0;
    end
  end

  task automatic preload(input logic [1:0] init, input int steps, input logic stuck);
    @(negedge clk);
    stub_init = init; stub_steps = steps; stub_stuck = stuck; stub_load = 1'b1;
    @(negedge clk);
    stub_load = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] tgt, input bit poke_busy,
                        output logic f, output int cnt, output bit got);
    @(negedge clk);
    req = 1'b1; target = tgt;
    @(negedge clk);
    req = 1'b0;
    check(ready == 1'b0, "R2 ready low after accept", ready, 0);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      req = 1'b1; target = ~tgt;
      @(negedge clk);
      req = 1'b0;
    end
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    f = fail; cnt = int'(pcnt);
    check(got, "R10 done seen", int'(got), 1);
    check(ready == 1'b1, "R10 ready with done", ready, 1);
    @(negedge clk);
    check(done == 1'b0 && fail == 1'b0, "R10 done one cycle", done, 0);
    check(int'(pcnt) == cnt, "R10 count held", int'(pcnt), cnt);
  endtask

  typedef struct packed {
    logic [1:0] tgt; logic [1:0] init; logic [3:0] steps;
    logic stuck; logic exp_fail; logic [3:0] exp_cnt;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'b11, 2'b00, 4'd1, 1'b0, 1'b0, 4'd1},   // R3
    '{2'b00, 2'b10, 4'd1, 1'b0, 1'b0, 4'd2},   // R4
    '{2'b01, 2'b11, 4'd1, 1'b0, 1'b0, 4'd3},   // R5
    '{2'b10, 2'b00, 4'd1, 1'b0, 1'b0, 4'd4},   // R5
    '{2'b01, 2'b01, 4'd3, 1'b0, 1'b0, 4'd5},   // R5
    '{2'b10, 2'b11, 4'd4, 1'b0, 1'b0, 4'd10},  // R8 match on last allowed
    '{2'b10, 2'b00, 4'd5, 1'b0, 1'b1, 4'd10},  // R8 budget exceeded
    '{2'b01, 2'b00, 4'd9, 1'b0, 1'b1, 4'd10},  // R8
    '{2'b11, 2'b01, 4'd1, 1'b1, 1'b1, 4'd1},   // R9 SET ignored
    '{2'b00, 2'b11, 4'd1, 1'b1, 1'b1, 4'd2}    // R9 RESET ignored
  };

  initial begin
    logic f; int cnt; bit got;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready", ready, 1);
    check({p_set, p_reset, p_part, verify} == 4'b0, "R1 commands", {p_set, p_reset, p_part, verify}, 0);
    check(done == 1'b0 && fail == 1'b0 && pcnt == '0, "R1 done/fail/cnt", int'(pcnt), 0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      preload(VECS[i].init, int'(VECS[i].steps), VECS[i].stuck);
      run_op(VECS[i].tgt, 1'b0, f, cnt, got);
      check(f == VECS[i].exp_fail, $sformatf("R3/R4/R5/R8/R9 fail flag vec%0d", i), f, VECS[i].exp_fail);
      check(cnt == int'(VECS[i].exp_cnt), $sformatf("R3/R4/R5/R8/R9 pulse count vec%0d", i), cnt, VECS[i].exp_cnt);
    end

    // R2 request during busy is ignored
    preload(2'b00, 2, 1'b0);
    run_op(2'b10, 1'b1, f, cnt, got);
    check(f == 1'b0, "R2 busy request ignored fail", f, 0);
    check(cnt == 6, "R2 busy request ignored count", cnt, 6);

    // R1 reset in mid-write
    preload(2'b00, 1, 1'b0);
    @(negedge clk); req = 1'b1; target = 2'b01;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ready == 1'b1 && {p_set, p_reset, p_part, verify} == 4'b0, "R1 mid-write reset", ready, 1);
    check(pcnt == '0, "R1 count cleared", int'(pcnt), 0);
    rst_n = 1'b1;
    preload(2'b10, 1, 1'b0);
    run_op(2'b11, 1'b0, f, cnt, got);
    check(f == 1'b0 && cnt == 1, "R3 after reset", cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errs);
    $finish;
  end
endmodule